// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a bus interface unit and an instruction decoder. Whenever the bus has no other work, it asks for the 16-bit code word that holds its running prefetch address. It does this only when the queue has room for the bytes that word will deliver. Returned bytes go into a small ring of byte slots, and the decoder takes them one per cycle without waiting for memory.

A control transfer (a taken jump, call or return) empties the ring and loads a new prefetch address in a single cycle. If a fetch is still in flight at that moment, its data is dropped when it comes back. Each cycle a two-bit code tells what the queue did: nothing, a flush, a byte handed out as the start of an instruction, or a byte handed out as a later byte of an instruction.

Top module: `fetch_queue`

## Requirements
- R1: While reset is held low, `dec_valid` is 0 and `q_status` is 00. After reset, `fetch_addr` equals the even word address of `RESET_ADDR`.
- R2: `fetch_req` is high only in these conditions: `bus_idle` is high, no fetch is in flight, `jump_valid` is low, and the free slots are at least 2 (even prefetch address) or at least 1 (odd prefetch address). A fetch is in flight from the cycle `fetch_gnt` is seen until `rsp_valid`.
- R3: `fetch_addr` is the prefetch address with bit 0 cleared.
- R4: A response for an even prefetch address queues `rsp_data[7:0]` and then `rsp_data[15:8]`, and the address advances by 2. A response for an odd address queues only `rsp_data[15:8]`, and the address advances by 1.
- R5: Bytes leave in the order they arrived. `dec_valid` is low when the queue is empty, and a read then removes nothing.
- R6: The queue never holds more than `DEPTH` (6) bytes. With 6 bytes held, `fetch_req` stays low.
- R7: `jump_valid` empties the queue by the next cycle and makes `jump_addr` the new prefetch address. No byte is taken in that cycle.
- R8: A response arriving for a fetch that was granted before a flush is discarded.
- R9: `q_status` is 01 when `jump_valid` is high. Otherwise it is 10 when a byte is taken with `dec_first` high, 11 when a byte is taken with `dec_first` low, and 00 when no byte is taken.
- R10: A byte taken in the same cycle as a response lowers the byte count by one against the pushed amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle | input | 1 | Bus has no other cycle to run |
| fetch_req | output | 1 | Code word fetch request |
| fetch_addr | output | AW | Even address of the requested word |
| fetch_gnt | input | 1 | Bus accepts the request this cycle |
| rsp_valid | input | 1 | Fetched word is present |
| rsp_data | input | 16 | Fetched word, low byte at the even address |
| jump_valid | input | 1 | Control transfer: flush and reload |
| jump_addr | input | AW | New prefetch byte address |
| dec_rd | input | 1 | Decoder takes a byte |
| dec_first | input | 1 | Taken byte starts an instruction |
| dec_valid | output | 1 | A byte is available |
| dec_byte | output | 8 | Oldest queued byte |
| q_status | output | 2 | Per-cycle queue activity code |

## Verification
The assertions assume that the bus interface raises `fetch_gnt` only in a cycle where `fetch_req` is high. They also assume that `rsp_valid` comes only once per granted fetch, at least one cycle after the grant. The bench's fetch tasks grant only after they have seen the request. They return data one cycle after the grant and hold `bus_idle` low while a fetch is in flight. The flush case places the flush after a grant but before the matching response, so the stale return path is exercised without ever giving the block an unrequested word.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FLUSH = 2'b01,
    QS_FIRST = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  // bytes a word fetch contributes, given bit 0 of the prefetch address
  function automatic int bytes_in_word(logic odd);
    return odd ? 1 : 2;
  endfunction

  // advance a ring index by step, wrapping at depth
  function automatic int ring_step(int p, int s, int depth);
    int n;
    n = p + s;
    if (n >= depth) n = n - depth;
    return n;
  endfunction
endpackage

// File: rtl/fq_store.sv
module fq_store #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  logic [7:0]    push_lo,
  input  logic [7:0]    push_hi,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] level
);
  import fq_pkg::*;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] level_q;
  logic [PW-1:0] wr_plus1_w, wr_next_w, rd_next_w;

  assign wr_plus1_w = PW'(ring_step(int'(wr_q), 1, DEPTH));
  assign wr_next_w  = PW'(ring_step(int'(wr_q), int'(push_n), DEPTH));
  assign rd_next_w  = PW'(ring_step(int'(rd_q), 1, DEPTH));

  always_ff @(posedge clk) begin
    if (!clr && push_n != 2'd0) mem[wr_q] <= push_lo;
    if (!clr && push_n == 2'd2) mem[wr_plus1_w] <= push_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0;
    end else if (clr) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0;
    end else begin
      wr_q    <= wr_next_w;
      if (pop) rd_q <= rd_next_w;
      level_q <= CW'(int'(level_q) + int'(push_n) - int'(pop));
    end
  end

  assign head  = mem[rd_q];
  assign level = level_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_q) <= DEPTH);
  p_push_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != 2'd0 && !clr) |-> int'(push_n) <= DEPTH - int'(level_q));
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level_q != '0);
endmodule

// File: rtl/fq_fetch_ctl.sv
module fq_fetch_ctl #(
  parameter int AW = 20,
  parameter int DEPTH = 6,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_idle,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic [CW-1:0] level,
  input  logic          fetch_gnt,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic [1:0]    push_n,
  output logic [7:0]    push_lo,
  output logic [7:0]    push_hi,
  output logic          discard
);
  import fq_pkg::*;

  logic [AW-1:0] pf_q;
  logic          inflight_q, discard_q;
  logic          odd_w, room_ok_w, accept_w;
  int            need_w, free_w;

  assign odd_w     = pf_q[0];
  assign need_w    = bytes_in_word(odd_w);
  assign free_w    = DEPTH - int'(level);
  assign room_ok_w = free_w >= need_w;
  assign fetch_req = bus_idle && !inflight_q && !flush && room_ok_w;
  assign fetch_addr = {pf_q[AW-1:1], 1'b0};
  assign accept_w  = rsp_valid && inflight_q && !discard_q && !flush;

  assign push_n  = accept_w ? 2'(need_w) : 2'd0;
  assign push_lo = odd_w ? rsp_data[15:8] : rsp_data[7:0];
  assign push_hi = rsp_data[15:8];
  assign discard = discard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= RESET_ADDR; inflight_q <= 1'b0; discard_q <= 1'b0;
    end else begin
      if (flush)         pf_q <= flush_addr;
      else if (accept_w) pf_q <= pf_q + AW'(need_w);
      if (fetch_req && fetch_gnt) inflight_q <= 1'b1;
      else if (rsp_valid)         inflight_q <= 1'b0;
      if (rsp_valid)                discard_q <= 1'b0;
      else if (flush && inflight_q) discard_q <= 1'b1;
    end
  end

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr[AW-1:1] == $past(flush_addr[AW-1:1]));
  p_stale_not_pushed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_q && rsp_valid) |-> push_n == 2'd0);
endmodule

// File: rtl/fq_status.sv
module fq_status (
  input  logic       flush,
  input  logic       pop,
  input  logic       first,
  output logic [1:0] code
);
  import fq_pkg::*;
  qstat_e st;
  always_comb begin
    if (flush)      st = QS_FLUSH;
    else if (!pop)  st = QS_IDLE;
    else if (first) st = QS_FIRST;
    else            st = QS_NEXT;
  end
  assign code = st;
endmodule

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int AW = 20,
  parameter int DEPTH = 6,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_idle,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_gnt,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  input  logic          jump_valid,
  input  logic [AW-1:0] jump_addr,
  input  logic          dec_rd,
  input  logic          dec_first,
  output logic          dec_valid,
  output logic [7:0]    dec_byte,
  output logic [1:0]    q_status
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] level_w;
  logic [1:0]    push_n_w;
  logic [7:0]    push_lo_w, push_hi_w;
  logic          pop_w, discard_w;

  assign dec_valid = level_w != '0;
  assign pop_w     = dec_rd && dec_valid && !jump_valid;

  fq_fetch_ctl #(.AW(AW), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
    .flush(jump_valid), .flush_addr(jump_addr), .level(level_w),
    .fetch_gnt(fetch_gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .push_n(push_n_w), .push_lo(push_lo_w), .push_hi(push_hi_w),
    .discard(discard_w)
  );

  fq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(jump_valid),
    .push_n(push_n_w), .push_lo(push_lo_w), .push_hi(push_hi_w),
    .pop(pop_w), .head(dec_byte), .level(level_w)
  );

  fq_status u_stat (
    .flush(jump_valid), .pop(pop_w), .first(dec_first), .code(q_status)
  );

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !dec_valid);
  p_stale_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_w && rsp_valid) |=> !dec_valid);
  p_full_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level_w) == DEPTH) |-> !fetch_req);
endmodule

// File: tb/fetch_queue_test.sv
module fetch_queue_test;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_idle = 1'b0, fetch_gnt = 1'b0, rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic jump_valid = 1'b0, dec_rd = 1'b0, dec_first = 1'b0;
  logic [AW-1:0] jump_addr = '0;
  logic fetch_req, dec_valid;
  logic [AW-1:0] fetch_addr;
  logic [7:0] dec_byte;
  logic [1:0] q_status;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  fetch_queue #(.AW(AW), .DEPTH(6), .RESET_ADDR('0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_gnt(fetch_gnt), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .jump_valid(jump_valid), .jump_addr(jump_addr),
    .dec_rd(dec_rd), .dec_first(dec_first), .dec_valid(dec_valid),
    .dec_byte(dec_byte), .q_status(q_status)
  );

  function automatic logic [7:0] mem_at(logic [AW-1:0] a);
    return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hA5;
  endfunction
  function automatic logic [15:0] word_at(logic [AW-1:0] a);
    return {mem_at({a[AW-1:1], 1'b1}), mem_at({a[AW-1:1], 1'b0})};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one granted fetch, data returned in the following cycle
  task automatic serve(logic [AW-1:0] exp_addr);
    @(negedge clk);
    bus_idle = 1'b1;
    #1;
    check("R2 request", fetch_req, 1);
    check("R3 word addr", fetch_addr, exp_addr);
    fetch_gnt = 1'b1;
    @(negedge clk);
    fetch_gnt = 1'b0; bus_idle = 1'b0;
    rsp_valid = 1'b1; rsp_data = word_at(exp_addr);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic take(logic [7:0] exp, logic first);
    @(negedge clk);
    dec_rd = 1'b1; dec_first = first;
    #1;
    check("R5 valid", dec_valid, 1);
    check("R5 byte order", dec_byte, exp);
    check("R9 status", q_status, first ? 2'b10 : 2'b11);
    @(posedge clk); #1;
    dec_rd = 1'b0; dec_first = 1'b0;
  endtask

  task automatic take_empty();
    @(negedge clk);
    dec_rd = 1'b1; dec_first = 1'b1;
    #1;
    check("R5 empty", dec_valid, 0);
    check("R9 idle code", q_status, 2'b00);
    @(posedge clk); #1;
    dec_rd = 1'b0; dec_first = 1'b0;
  endtask

  task automatic jump(logic [AW-1:0] a);
    @(negedge clk);
    jump_valid = 1'b1; jump_addr = a; dec_rd = 1'b1;
    #1;
    check("R9 flush code", q_status, 2'b01);
    @(posedge clk); #1;
    jump_valid = 1'b0; dec_rd = 1'b0;
  endtask

  task automatic t_reset();
    bus_idle = 1'b1;
    #1;
    check("R1 valid in reset", dec_valid, 0);
    check("R1 status in reset", q_status, 2'b00);
    bus_idle = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset address", fetch_addr, 0);
  endtask

  task automatic t_idle_gate();
    @(negedge clk); bus_idle = 1'b0; #1;
    check("R2 busy bus", fetch_req, 0);
  endtask

  task automatic t_fill_drain();
    serve(20'h0); serve(20'h2); serve(20'h4);
    @(negedge clk); bus_idle = 1'b1; #1;
    check("R6 full no request", fetch_req, 0);
    check("R4 next addr", fetch_addr, 20'h6);
    bus_idle = 1'b0;
    for (int i = 0; i < 6; i++) take(mem_at(AW'(i)), (i == 0) || (i == 3));
    take_empty();
  endtask

  task automatic t_flush_full();
    serve(20'h6); serve(20'h8); serve(20'hA);
    jump(20'h203);
    @(negedge clk); #1;
    check("R7 emptied", dec_valid, 0);
    check("R7 reload", fetch_addr, 20'h202);
  endtask

  task automatic t_odd_room();
    serve(20'h202);
    @(negedge clk); #1;
    check("R4 odd advance", fetch_addr, 20'h204);
    serve(20'h204); serve(20'h206);
    @(negedge clk); bus_idle = 1'b1; #1;
    check("R2 one slot even", fetch_req, 0);
    bus_idle = 1'b0;
    take(mem_at(20'h203), 1'b1);
    @(negedge clk); bus_idle = 1'b1; #1;
    check("R2 two slots", fetch_req, 1);
    check("R3 addr", fetch_addr, 20'h208);
    bus_idle = 1'b0;
    for (int i = 4; i < 8; i++) take(mem_at(20'h200 + AW'(i)), 1'b0);
    take_empty();
  endtask

  task automatic t_discard();
    @(negedge clk); bus_idle = 1'b1; fetch_gnt = 1'b1;
    @(negedge clk); fetch_gnt = 1'b0; bus_idle = 1'b0;
    jump_valid = 1'b1; jump_addr = 20'h400;
    @(negedge clk); jump_valid = 1'b0;
    rsp_valid = 1'b1; rsp_data = word_at(20'h208);
    @(negedge clk); rsp_valid = 1'b0; bus_idle = 1'b1; #1;
    check("R8 stale dropped", dec_valid, 0);
    check("R8 new fetch", fetch_addr, 20'h400);
    bus_idle = 1'b0;
    serve(20'h400);
    take(mem_at(20'h400), 1'b1);
  endtask

  task automatic t_pushpop();
    @(negedge clk); bus_idle = 1'b1; #1;
    check("R3 addr", fetch_addr, 20'h402);
    fetch_gnt = 1'b1;
    @(negedge clk);
    fetch_gnt = 1'b0; bus_idle = 1'b0;
    rsp_valid = 1'b1; rsp_data = word_at(20'h402); dec_rd = 1'b1;
    #1;
    check("R10 popped byte", dec_byte, mem_at(20'h401));
    check("R10 status", q_status, 2'b11);
    @(posedge clk); #1;
    rsp_valid = 1'b0; dec_rd = 1'b0;
    take(mem_at(20'h402), 1'b1);
    take(mem_at(20'h403), 1'b0);
    @(negedge clk); #1;
    check("R10 count after push and pop", dec_valid, 0);
  endtask

  initial begin
    t_reset();
    t_idle_gate();
    t_fill_drain();
    t_flush_full();
    t_odd_room();
    t_discard();
    t_pushpop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule